// File: doc/BRIEF.md
# Eight-Bit Up/Down Timer with One Compare Channel

The block is an eight-bit timer/counter driven by a tick enable. On every tick it either counts up, counts down, or returns to zero. A three-bit clock-select field chooses the tick rate from a free-running divider of the system clock, or stops the timer altogether. Two counting schemes are offered. The first is a plain up-count that wraps from the maximum back to zero. The second is a triangle count that turns around at the maximum and again at zero.

A comparator watches the count against a compare register. When it sees equality, it raises a sticky match flag on the tick that follows and drives a waveform pin according to an output-mode field. A sticky overflow flag marks the end of each counting period. Each flag has its own interrupt enable. Software clears a flag by writing a one to its bit, and hardware clears it with an acknowledge pulse. Software reaches every register over a simple single-cycle register bus. A software write to the count always wins over the timer's own update in the same cycle, and it masks the compare logic for one tick.

Register map (byte addresses on `bus_addr`):
- 0 control: [1:0] counting scheme (1 = triangle, any other value = wrap-around), [3:2] output mode, [6:4] clock select.
- 1 count.
- 2 compare value.
- 3 interrupt enables: [0] match, [1] overflow.
- 4 flags: [0] match, [1] overflow. Writing a one to a bit clears that flag.

Unused addresses read as zero.

Top module: `tmr8_cmp`

## Requirements
- R1: After reset the following all read zero: count, control, compare value, enables and flags. At the pins, `at_bottom`=1 and `wave_out`, `cmp_irq`, `ovf_irq` and `at_top` are all 0.
- R2: While clock select is 0, no tick occurs and the count holds its value. The count is still readable and writable at address 1.
- R3: Clock select values 1,2,3,4,5,6,7 give one tick every 1,8,32,64,128,256,1024 clock cycles respectively. Any window of 4·N cycles therefore advances a wrap-around count by exactly 4.
- R4: In wrap-around mode each tick adds one. A tick taken at 255 loads 0 and sets the overflow flag (flags bit 1).
- R5: In triangle mode the count climbs to 255 and then steps down; it falls to 0 and then steps up (…FD,FE,FF,FE… and …2,1,0,1…). A tick taken while the count is 0 sets the overflow flag. The reverse at 255 does not set it.
- R6: `at_top` is 1 exactly when the count is 255. `at_bottom` is 1 exactly when the count is 0.
- R7: A tick taken while the count equals the compare value sets the match flag (flags bit 0). Arriving at the compare value does not set it by itself.
- R8: A count write in the same cycle as a tick loads the written value. That tick is then discarded: it changes neither count, direction, flags nor waveform.
- R9: The first tick after a count write cannot set the match flag or act on the waveform, even when the count equals the compare value.
- R10: `cmp_irq` = match flag AND enable bit 0. `ovf_irq` = overflow flag AND enable bit 1.
- R11: A flag clears when its bit is written as one at address 4, or when its acknowledge input (`cmp_ack`, `ovf_ack`) is pulsed high. Writing zero to the bit leaves the flag alone.
- R12: In wrap-around mode a compare hit acts on the waveform according to output mode: 1 toggles it, 2 drives it low, 3 drives it high. Output mode 0 holds `wave_out` at 0.
- R13: In triangle mode with output mode 2, a hit while counting up drives the waveform low and a hit while counting down drives it high. Output mode 3 does the opposite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| cmp_ack | input | 1 | Clears the match flag |
| ovf_ack | input | 1 | Clears the overflow flag |
| wave_out | output | 1 | Compare waveform |
| cmp_irq | output | 1 | Match interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| at_top | output | 1 | Count is at maximum |
| at_bottom | output | 1 | Count is zero |

## Verification
The bench first steps the count right up to the compare value and confirms that the match flag stays clear until one more tick. A design that raised the flag on equality itself would show it a tick early. It then reloads the count exactly at the compare value. A design without the post-write mask would report a spurious match there. A further test writes the count on a cycle that also carries a tick; a design that lets the tick through would read back one higher. In triangle mode the bench checks both turn-arounds, confirms that overflow comes only from the bottom, and walks a full up-and-down sweep to show that the waveform drives differently on the rising and falling passes. Finally, every clock-select code is checked over a window of four periods, which catches a divider tap that is off by a power of two.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

  typedef enum logic [2:0] {
    ACT_HOLD,
    ACT_CLR,
    ACT_INC,
    ACT_DEC,
    ACT_LOAD
  } cnt_act_e;

  typedef enum logic [1:0] {
    OUT_OFF = 2'd0,
    OUT_TGL = 2'd1,
    OUT_LOW = 2'd2,
    OUT_HIGH = 2'd3
  } out_mode_e;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_COUNT = 3'd1;
  localparam logic [2:0] ADDR_CMP   = 3'd2;
  localparam logic [2:0] ADDR_IEN   = 3'd3;
  localparam logic [2:0] ADDR_FLAGS = 3'd4;

  localparam logic [1:0] SCHEME_TRI = 2'd1;

  // log2 of the divide ratio for each clock-select code
  function automatic int unsigned tap_shift(input logic [2:0] sel);
    case (sel)
      3'd1:    tap_shift = 0;
      3'd2:    tap_shift = 3;
      3'd3:    tap_shift = 5;
      3'd4:    tap_shift = 6;
      3'd5:    tap_shift = 7;
      3'd6:    tap_shift = 8;
      3'd7:    tap_shift = 10;
      default: tap_shift = 0;
    endcase
  endfunction

endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [PRE_W-1:0] tap_mask;

  always_comb begin
    pre_d    = pre_q + 1'b1;
    tap_mask = PRE_W'((32'd1 << tap_shift(sel)) - 32'd1);
    tick     = (sel != 3'd0) && ((pre_q & tap_mask) == tap_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/tmr8_counter.sv
module tmr8_counter
  import tmr8_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ev,
  input  logic          tri_mode,
  input  logic          ld,
  input  logic [DW-1:0] ld_val,
  output logic [DW-1:0] cnt,
  output logic          dir_up,
  output logic          blk
);

  localparam logic [DW-1:0] CNT_MAX = '1;

  cnt_act_e      act;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          blk_q, blk_d;

  always_comb begin
    act   = ACT_HOLD;
    dir_d = dir_q;
    blk_d = blk_q;
    if (ld) begin
      act   = ACT_LOAD;
      blk_d = 1'b1;
    end else if (tick_ev) begin
      blk_d = 1'b0;
      if (!tri_mode) begin
        dir_d = 1'b1;
        act   = (cnt_q == CNT_MAX) ? ACT_CLR : ACT_INC;
      end else if (dir_q) begin
        if (cnt_q == CNT_MAX) begin
          dir_d = 1'b0;
          act   = ACT_DEC;
        end else begin
          act = ACT_INC;
        end
      end else begin
        if (cnt_q == '0) begin
          dir_d = 1'b1;
          act   = ACT_INC;
        end else begin
          act = ACT_DEC;
        end
      end
    end
    case (act)
      ACT_CLR:  cnt_d = '0;
      ACT_INC:  cnt_d = cnt_q + 1'b1;
      ACT_DEC:  cnt_d = cnt_q - 1'b1;
      ACT_LOAD: cnt_d = ld_val;
      default:  cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      blk_q <= blk_d;
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = dir_q;
  assign blk    = blk_q;

endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  out_mode_e omode,
  input  logic      tri_mode,
  input  logic      dir_up,
  output logic      wave
);

  logic wave_q, wave_d;
  logic drive_high;

  always_comb begin
    // in triangle mode the falling pass inverts the set/clear sense
    drive_high = (omode == OUT_HIGH);
    if (tri_mode && !dir_up) drive_high = !drive_high;
    wave_d = wave_q;
    if (hit) begin
      case (omode)
        OUT_TGL:  wave_d = !wave_q;
        OUT_LOW,
        OUT_HIGH: wave_d = drive_high;
        default:  wave_d = wave_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = (omode == OUT_OFF) ? 1'b0 : wave_q;

endmodule

// File: rtl/tmr8_cmp.sv
module tmr8_cmp
  import tmr8_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PRE_W = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cmp_ack,
  input  logic          ovf_ack,
  output logic          wave_out,
  output logic          cmp_irq,
  output logic          ovf_irq,
  output logic          at_top,
  output logic          at_bottom
);

  localparam int            CTRL_W  = 7;
  localparam logic [DW-1:0] CNT_MAX = '1;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [DW-1:0]     cmp_q, cmp_d;
  logic [1:0]        ien_q, ien_d;
  logic              mflag_q, mflag_d;
  logic              oflag_q, oflag_d;

  logic          wr_ctrl, wr_cnt, wr_cmp, wr_ien, wr_flags;
  logic          tick_raw, tick_ev, tri_mode;
  logic          cmp_hit, ovf_hit;
  logic [DW-1:0] count;
  logic          dir_up, blk;
  out_mode_e     omode;

  always_comb begin
    wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
    wr_cnt   = bus_wr && (bus_addr == ADDR_COUNT);
    wr_cmp   = bus_wr && (bus_addr == ADDR_CMP);
    wr_ien   = bus_wr && (bus_addr == ADDR_IEN);
    wr_flags = bus_wr && (bus_addr == ADDR_FLAGS);
  end

  assign tri_mode = (ctrl_q[1:0] == SCHEME_TRI);
  assign omode    = out_mode_e'(ctrl_q[3:2]);
  assign tick_ev  = tick_raw && !wr_cnt;

  tmr8_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk   (clk),
    .rst_n (rst_i),
    .sel   (ctrl_q[6:4]),
    .tick  (tick_raw)
  );

  tmr8_counter #(.DW(DW)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick_ev  (tick_ev),
    .tri_mode (tri_mode),
    .ld       (wr_cnt),
    .ld_val   (bus_wdata),
    .cnt      (count),
    .dir_up   (dir_up),
    .blk      (blk)
  );

  always_comb begin
    cmp_hit = tick_ev && !blk && (count == cmp_q);
    ovf_hit = tick_ev && (tri_mode ? (count == '0) : (count == CNT_MAX));
  end

  tmr8_wave i_wave (
    .clk      (clk),
    .rst_n    (rst_i),
    .hit      (cmp_hit),
    .omode    (omode),
    .tri_mode (tri_mode),
    .dir_up   (dir_up),
    .wave     (wave_out)
  );

  // next-state for the register file and flags
  always_comb begin
    ctrl_d  = wr_ctrl ? bus_wdata[CTRL_W-1:0] : ctrl_q;
    cmp_d   = wr_cmp  ? bus_wdata : cmp_q;
    ien_d   = wr_ien  ? bus_wdata[1:0] : ien_q;
    mflag_d = cmp_hit || (mflag_q && !(wr_flags && bus_wdata[0]) && !cmp_ack);
    oflag_d = ovf_hit || (oflag_q && !(wr_flags && bus_wdata[1]) && !ovf_ack);
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q  <= '0;
      cmp_q   <= '0;
      ien_q   <= '0;
      mflag_q <= 1'b0;
      oflag_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      cmp_q   <= cmp_d;
      ien_q   <= ien_d;
      mflag_q <= mflag_d;
      oflag_q <= oflag_d;
    end
  end

  always_comb begin
    case (bus_addr)
      ADDR_CTRL:  bus_rdata = DW'(ctrl_q);
      ADDR_COUNT: bus_rdata = count;
      ADDR_CMP:   bus_rdata = cmp_q;
      ADDR_IEN:   bus_rdata = DW'(ien_q);
      ADDR_FLAGS: bus_rdata = DW'({oflag_q, mflag_q});
      default:    bus_rdata = '0;
    endcase
  end

  assign cmp_irq   = mflag_q && ien_q[0];
  assign ovf_irq   = oflag_q && ien_q[1];
  assign at_top    = (count == CNT_MAX);
  assign at_bottom = (count == '0);

endmodule

// File: rtl/tmr8_cmp_chk.sv
module tmr8_cmp_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_i,
  input logic          tick_raw,
  input logic          tick_ev,
  input logic          wr_cnt,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] count,
  input logic [DW-1:0] cmp_val,
  input logic          blk,
  input logic          tri_mode,
  input logic          dir_up,
  input logic          mflag,
  input logic          oflag,
  input logic          cmp_ack,
  input logic          cmp_hit
);

  localparam logic [DW-1:0] CNT_MAX = '1;

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (!tick_raw && !wr_cnt) |=> $stable(count));

  // R4
  wrap_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (tick_ev && !tri_mode && count == CNT_MAX) |=> (count == '0 && oflag));

  // R5
  top_reverse_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (tick_ev && tri_mode && dir_up && count == CNT_MAX) |=> (count == CNT_MAX - 1'b1));

  // R7
  match_flag_origin_chk: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(mflag) |-> $past(tick_ev && !blk && count == cmp_val));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_i)
    wr_cnt |=> (count == $past(wdata)));

  // R11
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_i)
    (cmp_ack && !cmp_hit) |=> !mflag);

endmodule

bind tmr8_cmp tmr8_cmp_chk #(.DW(DW)) i_chk (
  .clk      (clk),
  .rst_i    (rst_i),
  .tick_raw (tick_raw),
  .tick_ev  (tick_ev),
  .wr_cnt   (wr_cnt),
  .wdata    (bus_wdata),
  .count    (count),
  .cmp_val  (cmp_q),
  .blk      (blk),
  .tri_mode (tri_mode),
  .dir_up   (dir_up),
  .mflag    (mflag_q),
  .oflag    (oflag_q),
  .cmp_ack  (cmp_ack),
  .cmp_hit  (cmp_hit)
);

// File: tb/test_tmr8_cmp.sv
`timescale 1ns/1ps
module test_tmr8_cmp;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_wr;
  logic [2:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       cmp_ack, ovf_ack;
  logic       wave_out, cmp_irq, ovf_irq, at_top, at_bottom;
  logic [4:0] pins;

  always #2.5 clk = ~clk;

  tmr8_cmp i_tmr8_cmp (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_ack(cmp_ack),
    .ovf_ack(ovf_ack), .wave_out(wave_out), .cmp_irq(cmp_irq),
    .ovf_irq(ovf_irq), .at_top(at_top), .at_bottom(at_bottom)
  );

  // pin vector: {wave, cmp_irq, ovf_irq, at_top, at_bottom}
  assign pins = {wave_out, cmp_irq, ovf_irq, at_top, at_bottom};

  typedef struct {
    bit         is_pin;
    logic [7:0] exp;
    logic [7:0] mask;
    string      tag;
  } item_t;

  item_t q[$];
  event  sample_ev;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // monitor: pops expected items and compares them with the design
  initial begin
    forever begin
      @(sample_ev);
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = q.pop_front();
        act = (it.is_pin ? {3'b000, pins} : bus_rdata) & it.mask;
        n_cmp++;
        if (act !== it.exp) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
    item_t it;
    bus_addr = a;
    #1;
    it.is_pin = 1'b0; it.exp = e; it.mask = 8'hFF; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    wait (q.size() == 0);
  endtask

  task automatic expect_pin(input logic [7:0] m, input logic [7:0] e, input string tag);
    item_t it;
    #1;
    it.is_pin = 1'b1; it.exp = e; it.mask = m; it.tag = tag;
    q.push_back(it);
    -> sample_ev;
    wait (q.size() == 0);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  function automatic logic [7:0] ctl(input logic [1:0] scheme, input logic [1:0] om,
                                     input logic [2:0] cs);
    return {1'b0, cs, om, scheme};
  endfunction

  // exactly n ticks at divide-by-1, then stopped
  task automatic run(input logic [1:0] scheme, input logic [1:0] om, input int n);
    wr(3'd0, ctl(scheme, om, 3'd1));
    cycles(n - 1);
    wr(3'd0, ctl(scheme, om, 3'd0));
  endtask

  task automatic pulse_cmp_ack();
    cmp_ack = 1'b1;
    @(posedge clk);
    @(negedge clk);
    cmp_ack = 1'b0;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int div_tab[7];
    div_tab = '{1, 8, 32, 64, 128, 256, 1024};
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    cmp_ack = 1'b0; ovf_ack = 1'b0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    // R1 reset state
    expect_reg(3'd1, 8'h00, "R1 count");
    expect_reg(3'd0, 8'h00, "R1 control");
    expect_reg(3'd4, 8'h00, "R1 flags");
    expect_pin(8'h1F, 8'h01, "R1 pins");

    // R2 stopped timer, count accessible
    wr(3'd1, 8'h37);
    cycles(20);
    expect_reg(3'd1, 8'h37, "R2 hold while stopped");

    // R6 top / bottom
    wr(3'd1, 8'hFF);
    expect_pin(8'h03, 8'h02, "R6 at_top");
    wr(3'd1, 8'h00);
    expect_pin(8'h03, 8'h01, "R6 at_bottom");

    // R4 wrap-around counting
    wr(3'd1, 8'h10);
    run(2'd0, 2'd0, 5);
    expect_reg(3'd1, 8'h15, "R4 increment");
    expect_reg(3'd4, 8'h00, "R4 no overflow");
    wr(3'd1, 8'hFD);
    run(2'd0, 2'd0, 3);
    expect_reg(3'd1, 8'h00, "R4 wrap");
    expect_reg(3'd4, 8'h02, "R4 overflow flag");

    // R10 overflow interrupt gating
    expect_pin(8'h04, 8'h00, "R10 ovf_irq disabled");
    wr(3'd3, 8'h02);
    expect_pin(8'h04, 8'h04, "R10 ovf_irq enabled");

    // R11 write-one-to-clear
    wr(3'd4, 8'h01);
    expect_reg(3'd4, 8'h02, "R11 other bit kept");
    wr(3'd4, 8'h00);
    expect_reg(3'd4, 8'h02, "R11 zero write ignored");
    wr(3'd4, 8'h02);
    expect_reg(3'd4, 8'h00, "R11 overflow cleared");

    // R7 match flag one tick after equality
    wr(3'd2, 8'h20);
    wr(3'd1, 8'h1E);
    run(2'd0, 2'd0, 1);
    run(2'd0, 2'd0, 1);
    expect_reg(3'd1, 8'h20, "R7 count at compare");
    expect_reg(3'd4, 8'h00, "R7 no flag on arrival");
    run(2'd0, 2'd0, 1);
    expect_reg(3'd4, 8'h01, "R7 flag after next tick");

    // R10 match interrupt gating
    expect_pin(8'h08, 8'h00, "R10 cmp_irq disabled");
    wr(3'd3, 8'h03);
    expect_pin(8'h08, 8'h08, "R10 cmp_irq enabled");

    // R11 acknowledge pulse
    pulse_cmp_ack();
    expect_reg(3'd4, 8'h00, "R11 ack clears");

    // R9 compare masked for one tick after a count write
    wr(3'd1, 8'h20);
    run(2'd0, 2'd0, 1);
    expect_reg(3'd1, 8'h21, "R9 count moved");
    expect_reg(3'd4, 8'h00, "R9 no match after write");

    // R8 write beats tick in the same cycle
    wr(3'd0, ctl(2'd0, 2'd0, 3'd1));
    wr(3'd1, 8'h80);
    expect_reg(3'd1, 8'h80, "R8 loaded value");
    wr(3'd0, ctl(2'd0, 2'd0, 3'd0));
    expect_reg(3'd1, 8'h81, "R8 one tick later");

    // R12 waveform in wrap-around mode
    wr(3'd2, 8'h40);
    wr(3'd1, 8'h3F);
    run(2'd0, 2'd1, 2);
    expect_pin(8'h10, 8'h10, "R12 toggle");
    wr(3'd0, ctl(2'd0, 2'd0, 3'd0));
    expect_pin(8'h10, 8'h00, "R12 disconnected");
    wr(3'd1, 8'h3F);
    run(2'd0, 2'd2, 2);
    expect_pin(8'h10, 8'h00, "R12 drive low");
    wr(3'd1, 8'h3F);
    run(2'd0, 2'd3, 2);
    expect_pin(8'h10, 8'h10, "R12 drive high");

    // R5 triangle counting
    wr(3'd4, 8'h03);
    wr(3'd1, 8'hFD);
    run(2'd1, 2'd3, 3);
    expect_reg(3'd1, 8'hFE, "R5 turn at top");
    expect_reg(3'd4, 8'h00, "R5 no overflow at top");
    wr(3'd1, 8'h02);
    run(2'd1, 2'd3, 3);
    expect_reg(3'd1, 8'h01, "R5 turn at bottom");
    expect_pin(8'h04, 8'h04, "R5 overflow at bottom");

    // R13 triangle waveform
    wr(3'd1, 8'h3F);
    run(2'd1, 2'd2, 2);
    expect_pin(8'h10, 8'h00, "R13 low on rising match");
    wr(3'd1, 8'h41);
    run(2'd1, 2'd2, 382);
    expect_reg(3'd1, 8'h3F, "R13 after full sweep");
    expect_pin(8'h10, 8'h10, "R13 high on falling match");

    // R3 clock-select divide ratios
    for (int c = 1; c <= 7; c++) begin
      wr(3'd1, 8'h00);
      wr(3'd0, ctl(2'd0, 2'd0, 3'(c)));
      cycles(4 * div_tab[c-1]);
      expect_reg(3'd1, 8'h04, $sformatf("R3 select %0d", c));
      wr(3'd0, ctl(2'd0, 2'd0, 3'd0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule